// File: doc/BRIEF.md
# Full-Bridge Command Decoder with Fault Supervision

This block sits between a two-bit drive command and the four gate enables of a full bridge built from two half-bridge legs. Leg 0 drives the first motor terminal and leg 1 drives the second. Each leg has a high-side enable and a low-side enable. The command is brought into the clock domain through a short flip-flop chain and decoded into forward, reverse, brake or all-off. A per-leg sequencer keeps both switches of a leg off for a programmable number of cycles before either switch turns on.

The block watches digital comparator flags and qualifies each flag with a cycle counter that must run uninterrupted for `QUAL_CYC` cycles. The flags are high-side overcurrent, low-side overcurrent, terminal-to-terminal short, the two open-load comparators, two temperature thresholds and two supply thresholds. A qualified overcurrent opens every switch and pulls the active-low error flag down. A later change of the synchronised command clears that error. A qualified terminal short is latched in a separate way that the command cannot clear. Open-load testing runs only while the all-off command is applied and affects only the flag. Over-temperature and supply lockout are hysteresis states, not latches: while one of them holds, the bridge is off and the flag is low.

Top module: `hbr_ctrl`

## Requirements
- R1: The synchronised command `{cmd_i[1],cmd_i[0]}` selects the drive: 2'b00 gives `hs_en_o=2'b01, ls_en_o=2'b10`; 2'b01 gives `hs_en_o=2'b10, ls_en_o=2'b01`; 2'b10 gives `hs_en_o=2'b00, ls_en_o=2'b11`; 2'b11 gives both buses 2'b00. Bit 0 of each bus is leg 0 and bit 1 is leg 1.
- R2: `hs_en_o[l]` and `ls_en_o[l]` are never both high for the same leg.
- R3: An enable of a leg turns on only after both enables of that leg have been low for at least `DEAD_CYC` consecutive cycles.
- R4: Suppose `flt_hs_oc_i` or `flt_ls_oc_i` stays high for `QUAL_CYC` consecutive cycles. The error latch then sets, `err_n_o` goes low, and all four enables go low. A shorter pulse has no effect.
- R5: A latched overcurrent or open-load error persists while the synchronised command stays at the value it had when the error latched. A change of that value clears the error, and normal drive resumes. Qualification then starts again from zero.
- R6: `flt_short_i` high for `QUAL_CYC` cycles latches a terminal-short error: all enables low and `err_n_o` low. Command changes do not clear it. Only reset or supply lockout clears it.
- R7: Open-load detection qualifies `ol_hi_i & ol_lo_i` only while the synchronised command is 2'b11. After `QUAL_CYC` cycles it latches `err_n_o` low. Under any other command these inputs have no effect.
- R8: `ot_hot_i` sets an over-temperature state and `ot_cool_i` (with `ot_hot_i` low) clears it. While the state is set, all enables are low and `err_n_o` is low. Once it clears, drive resumes without a command change.
- R9: `sup_low_i` sets a lockout state and `sup_good_i` (with `sup_low_i` low) clears it. Lockout forces all enables low and `err_n_o` low. It also clears every latched error, including the terminal-short latch.
- R10: Asynchronous reset (`rst_n` low) clears all latches and places the block in lockout with the synchronised command at 2'b11. During reset all enables and `err_n_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Drive command, asynchronous |
| flt_hs_oc_i | input | 1 | High-side overcurrent flag |
| flt_ls_oc_i | input | 1 | Low-side overcurrent flag |
| flt_short_i | input | 1 | Terminal-to-terminal short flag |
| ol_hi_i | input | 1 | Open-load comparator: terminal 1 near supply |
| ol_lo_i | input | 1 | Open-load comparator: terminal 2 near ground |
| ot_hot_i | input | 1 | Temperature above trip threshold |
| ot_cool_i | input | 1 | Temperature below release threshold |
| sup_low_i | input | 1 | Supply below switch-off threshold |
| sup_good_i | input | 1 | Supply above switch-on threshold |
| hs_en_o | output | 2 | High-side enables, one per leg |
| ls_en_o | output | 2 | Low-side enables, one per leg |
| err_n_o | output | 1 | Active-low error flag |

## Verification
Timing is counted from the rising edge that first samples an input change. A command change reaches the enables on the third edge when no dead time applies. When a switch of a leg must change side, the new switch turns on `DEAD_CYC`+1 edges after the old one turns off. A qualified fault pulls `err_n_o` low `QUAL_CYC`+1 edges after it is first sampled, and the enables drop one edge after that. Temperature and supply thresholds move the flag after one edge and the enables after two. The bench advances a behavioural model on each rising edge and compares every output with it at each falling edge. Spot checks sample at exactly these edge counts.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic [1:0] {
      CMD_CW    = 2'b00,
      CMD_CCW   = 2'b01,
      CMD_BRAKE = 2'b10,
      CMD_OFF   = 2'b11
   } hbr_cmd_e;

   localparam int NUM_LEGS = 2;

   // qualifier channel indices
   localparam int FC_HS    = 0;
   localparam int FC_LS    = 1;
   localparam int FC_SHORT = 2;
   localparam int FC_OPEN  = 3;
   localparam int NUM_FC   = 4;

   typedef struct packed {
      logic hs;
      logic ls;
   } leg_drv_t;

   typedef leg_drv_t [NUM_LEGS-1:0] bridge_drv_t;

   function automatic bridge_drv_t hbr_decode(input hbr_cmd_e c);
      bridge_drv_t d;
      d = '0;
      unique case (c)
         CMD_CW: begin
            d[0].hs = 1'b1;
            d[1].ls = 1'b1;
         end
         CMD_CCW: begin
            d[0].ls = 1'b1;
            d[1].hs = 1'b1;
         end
         CMD_BRAKE: begin
            d[0].ls = 1'b1;
            d[1].ls = 1'b1;
         end
         default: d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int unsigned     W       = 2,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {STAGES{RST_VAL}};
      end else begin
         pipe_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/hbr_qual.sv
module hbr_qual #(
   parameter int unsigned DLY = 6250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   input  logic clr_i,
   output logic qual_o
);

   localparam int unsigned   CW  = $clog2(DLY + 1);
   localparam logic [CW-1:0] LIM = CW'(DLY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || !in_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LIM) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign qual_o = (cnt_q == LIM);

endmodule

// File: rtl/hbr_hyst.sv
module hbr_hyst #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic state_o
);

   logic st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RST_VAL;
      end else if (set_i) begin
         st_q <= 1'b1;
      end else if (clr_i) begin
         st_q <= 1'b0;
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/hbr_leg.sv
module hbr_leg
   import hbr_pkg::*;
#(
   parameter int unsigned DEAD = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_drv_t want_i,
   output leg_drv_t drv_o
);

   leg_drv_t drv_q;
   logic     settled;

   generate
      if (DEAD == 0) begin : g_nodead
         assign settled = !(drv_q.hs || drv_q.ls);
      end else begin : g_dead
         localparam int unsigned   CW  = $clog2(DEAD + 1);
         localparam logic [CW-1:0] LIM = CW'(DEAD);
         logic [CW-1:0] idle_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idle_q <= '0;
            end else if (drv_q.hs || drv_q.ls) begin
               idle_q <= '0;
            end else if (idle_q != LIM) begin
               idle_q <= idle_q + CW'(1);
            end
         end

         assign settled = !(drv_q.hs || drv_q.ls) && (idle_q == LIM);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= '0;
      end else begin
         drv_q.hs <= want_i.hs && (drv_q.hs || settled);
         drv_q.ls <= want_i.ls && (drv_q.ls || settled);
      end
   end

   assign drv_o = drv_q;

endmodule

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
   import hbr_pkg::*;
#(
   parameter int unsigned QUAL_CYC    = 6250,
   parameter int unsigned DEAD_CYC    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cmd_i,
   input  logic       flt_hs_oc_i,
   input  logic       flt_ls_oc_i,
   input  logic       flt_short_i,
   input  logic       ol_hi_i,
   input  logic       ol_lo_i,
   input  logic       ot_hot_i,
   input  logic       ot_cool_i,
   input  logic       sup_low_i,
   input  logic       sup_good_i,
   output logic [1:0] hs_en_o,
   output logic [1:0] ls_en_o,
   output logic       err_n_o
);

   // elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hbr_ctrl: SYNC_STAGES must be at least 2");
      end
      if (QUAL_CYC < 1) begin : g_bad_qual
         $error("hbr_ctrl: QUAL_CYC must be at least 1");
      end
   endgenerate

   logic [1:0] cmd_s;
   logic       ot_q, uv_q;
   logic       trip_q, open_q, short_q;
   logic [1:0] cap_q;
   logic       hold, shut, qual_clr;
   logic       trip_set, open_set, short_set;

   logic [NUM_FC-1:0] fc_in, fc_q;
   bridge_drv_t       want;
   leg_drv_t          drv [NUM_LEGS];

   // command synchroniser
   hbr_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_cmd_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmd_i),
      .q_o   (cmd_s)
   );

   // threshold hysteresis states
   hbr_hyst #(.RST_VAL(1'b0)) u_temp (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ot_hot_i),
      .clr_i   (ot_cool_i),
      .state_o (ot_q)
   );

   hbr_hyst #(.RST_VAL(1'b1)) u_supply (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (sup_low_i),
      .clr_i   (sup_good_i),
      .state_o (uv_q)
   );

   // persistence qualifiers
   assign fc_in[FC_HS]    = flt_hs_oc_i;
   assign fc_in[FC_LS]    = flt_ls_oc_i;
   assign fc_in[FC_SHORT] = flt_short_i;
   assign fc_in[FC_OPEN]  = ol_hi_i && ol_lo_i && (cmd_s == CMD_OFF);

   assign hold     = trip_q || open_q || short_q;
   assign qual_clr = hold || uv_q;

   generate
      for (genvar f = 0; f < NUM_FC; f++) begin : g_qual
         hbr_qual #(.DLY(QUAL_CYC)) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (fc_in[f]),
            .clr_i  (qual_clr),
            .qual_o (fc_q[f])
         );
      end
   endgenerate

   assign trip_set  = !hold && (fc_q[FC_HS] || fc_q[FC_LS]);
   assign open_set  = !hold && fc_q[FC_OPEN];
   assign short_set = !hold && fc_q[FC_SHORT];

   // fault latches: overcurrent and open-load clear on command change,
   // terminal short only on reset or lockout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_q  <= 1'b0;
         open_q  <= 1'b0;
         short_q <= 1'b0;
         cap_q   <= CMD_OFF;
      end else if (uv_q) begin
         trip_q  <= 1'b0;
         open_q  <= 1'b0;
         short_q <= 1'b0;
      end else if (!hold) begin
         if (trip_set)  trip_q  <= 1'b1;
         if (open_set)  open_q  <= 1'b1;
         if (short_set) short_q <= 1'b1;
         if (trip_set || open_set) cap_q <= cmd_s;
      end else if ((trip_q || open_q) && (cmd_s != cap_q)) begin
         trip_q <= 1'b0;
         open_q <= 1'b0;
      end
   end

   // decode and leg sequencing
   assign shut = trip_q || short_q || ot_q || uv_q;

   always_comb begin
      want = shut ? '0 : hbr_decode(hbr_cmd_e'(cmd_s));
   end

   generate
      for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
         hbr_leg #(.DEAD(DEAD_CYC)) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .want_i (want[l]),
            .drv_o  (drv[l])
         );
         assign hs_en_o[l] = drv[l].hs;
         assign ls_en_o[l] = drv[l].ls;
      end
   endgenerate

   assign err_n_o = !(hold || ot_q || uv_q);

endmodule

// File: rtl/hbr_ctrl_chk.sv
module hbr_ctrl_chk #(
   parameter int unsigned DEAD_CYC = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] hs_en_o,
   input logic [1:0] ls_en_o,
   input logic       err_n_o,
   input logic       flt_hs_oc_i,
   input logic       flt_ls_oc_i,
   input logic       ot_hot_i,
   input logic       sup_low_i,
   input logic       trip_q,
   input logic       short_q,
   input logic       uv_q
);

   localparam int unsigned   GW  = $clog2(DEAD_CYC + 2);
   localparam logic [GW-1:0] GLIM = GW'(DEAD_CYC);

   assert_leg_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en_o & ls_en_o) == 2'b00);

   for (genvar l = 0; l < 2; l++) begin : g_gap
      logic [GW-1:0] gap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gap_q <= '0;
         end else if (hs_en_o[l] || ls_en_o[l]) begin
            gap_q <= '0;
         end else if (gap_q < GLIM) begin
            gap_q <= gap_q + GW'(1);
         end
      end

      assert_dead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(hs_en_o[l]) || $rose(ls_en_o[l])) |-> (gap_q >= GLIM));
   end

   assert_trip_needs_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_q) |-> $past(flt_hs_oc_i || flt_ls_oc_i, 2));

   assert_short_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (short_q && !uv_q) |=> short_q);

   assert_hot_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ot_hot_i |=> !err_n_o);

   assert_hot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ot_hot_i |=> ##1 (hs_en_o == 2'b00 && ls_en_o == 2'b00));

   assert_lockout_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sup_low_i |=> ##1 (hs_en_o == 2'b00 && ls_en_o == 2'b00));

   assert_lockout_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |=> (!trip_q && !short_q));

endmodule

bind hbr_ctrl hbr_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hs_en_o     (hs_en_o),
   .ls_en_o     (ls_en_o),
   .err_n_o     (err_n_o),
   .flt_hs_oc_i (flt_hs_oc_i),
   .flt_ls_oc_i (flt_ls_oc_i),
   .ot_hot_i    (ot_hot_i),
   .sup_low_i   (sup_low_i),
   .trip_q      (trip_q),
   .short_q     (short_q),
   .uv_q        (uv_q)
);

// File: tb/hbr_ctrl_tb_top.sv
module hbr_ctrl_tb_top;

   localparam int QD = 20;
   localparam int DT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b11;
   logic       hs_oc = 0, ls_oc = 0, lsh = 0, olh = 0, oll = 0;
   logic       hot = 0, cool = 1, slow = 0, sgood = 0;
   logic [1:0] hs, ls;
   logic       errn;

   always #4 clk = ~clk;

   hbr_ctrl #(.QUAL_CYC(QD), .DEAD_CYC(DT), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
      .flt_hs_oc_i(hs_oc), .flt_ls_oc_i(ls_oc), .flt_short_i(lsh),
      .ol_hi_i(olh), .ol_lo_i(oll), .ot_hot_i(hot), .ot_cool_i(cool),
      .sup_low_i(slow), .sup_good_i(sgood),
      .hs_en_o(hs), .ls_en_o(ls), .err_n_o(errn));

   int    checks = 0, errors = 0;
   string req = "R10";
   bit    done = 0;

   task automatic check(string r, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference model, advanced on each rising edge
   int mp1 = 3, mp2 = 3, mcap = 3;
   int mrun [4];
   bit mtrip = 0, mopen = 0, mshort = 0, mot = 0, muv = 1;
   bit mh [2], ml [2];
   int midle [2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp1 = 3; mp2 = 3; mcap = 3;
         mtrip = 0; mopen = 0; mshort = 0; mot = 0; muv = 1;
         for (int i = 0; i < 4; i++) mrun[i] = 0;
         for (int l = 0; l < 2; l++) begin mh[l] = 0; ml[l] = 0; midle[l] = 0; end
      end else begin : step
         bit hold, shut, settled, nh, nl;
         bit cond [4];
         bit q [4];
         bit wh [2];
         bit wl [2];
         hold = mtrip | mopen | mshort;
         shut = mtrip | mshort | mot | muv;
         cond[0] = hs_oc; cond[1] = ls_oc; cond[2] = lsh;
         cond[3] = olh & oll & (mp2 == 3);
         for (int i = 0; i < 4; i++) begin
            q[i] = (mrun[i] >= QD);
            if (hold || muv || !cond[i]) mrun[i] = 0;
            else if (mrun[i] < QD) mrun[i] = mrun[i] + 1;
         end
         if (muv) begin
            mtrip = 0; mopen = 0; mshort = 0;
         end else if (!hold) begin
            if (q[0] | q[1]) mtrip = 1;
            if (q[2]) mshort = 1;
            if (q[3]) mopen = 1;
            if (q[0] | q[1] | q[3]) mcap = mp2;
         end else if ((mtrip | mopen) && mp2 != mcap) begin
            mtrip = 0; mopen = 0;
         end
         for (int l = 0; l < 2; l++) begin wh[l] = 0; wl[l] = 0; end
         if (!shut) begin
            case (mp2)
               0: begin wh[0] = 1; wl[1] = 1; end
               1: begin wl[0] = 1; wh[1] = 1; end
               2: begin wl[0] = 1; wl[1] = 1; end
               default: ;
            endcase
         end
         for (int l = 0; l < 2; l++) begin
            settled = !mh[l] && !ml[l] && (midle[l] >= DT);
            nh = wh[l] && (mh[l] || settled);
            nl = wl[l] && (ml[l] || settled);
            if (mh[l] || ml[l]) midle[l] = 0;
            else if (midle[l] < DT) midle[l] = midle[l] + 1;
            mh[l] = nh;
            ml[l] = nl;
         end
         if (hot) mot = 1; else if (cool) mot = 0;
         if (slow) muv = 1; else if (sgood) muv = 0;
         mp2 = mp1;
         mp1 = int'(cmd);
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         check(req, {3'b0, hs, ls, errn},
               {3'b0, mh[1], mh[0], ml[1], ml[0],
                !(mtrip | mshort | mopen | mot | muv)});
      end
   end

   initial begin
      cyc(3);
      check("R10", {3'b0, hs, ls, errn}, 8'h00);
      rst_n = 1'b1;
      cyc(2);

      req = "R9"; sgood = 1;
      cyc(2);
      check("R9", {7'b0, errn}, 8'h01);

      req = "R1"; cmd = 2'b00;
      cyc(10);
      check("R1", {4'b0, hs, ls}, 8'h06);
      req = "R3"; cmd = 2'b01;
      cyc(6);
      check("R3", {4'b0, hs, ls}, 8'h00);
      cyc(1);
      check("R3", {4'b0, hs, ls}, 8'h09);
      req = "R1"; cmd = 2'b10;
      cyc(10);
      check("R1", {4'b0, hs, ls}, 8'h03);
      cmd = 2'b11;
      cyc(6);
      check("R1", {4'b0, hs, ls}, 8'h00);

      req = "R7"; cmd = 2'b00;
      cyc(8);
      olh = 1; oll = 1;
      cyc(40);
      check("R7", {7'b0, errn}, 8'h01);
      cmd = 2'b11;
      cyc(40);
      check("R7", {4'b0, hs, ls}, 8'h00);
      check("R7", {7'b0, errn}, 8'h00);
      olh = 0; oll = 0; cmd = 2'b00; req = "R5";
      cyc(12);
      check("R5", {3'b0, hs, ls, errn}, 8'h0D);

      req = "R4"; hs_oc = 1;
      cyc(10);
      hs_oc = 0;
      cyc(5);
      check("R4", {3'b0, hs, ls, errn}, 8'h0D);
      hs_oc = 1;
      cyc(30);
      hs_oc = 0;
      check("R4", {3'b0, hs, ls, errn}, 8'h00);
      req = "R5";
      cyc(10);
      check("R5", {7'b0, errn}, 8'h00);
      cmd = 2'b01;
      cyc(12);
      check("R5", {3'b0, hs, ls, errn}, 8'h13);

      req = "R4"; ls_oc = 1;
      cyc(25);
      ls_oc = 0;
      check("R4", {7'b0, errn}, 8'h00);
      req = "R5"; cmd = 2'b10;
      cyc(12);
      check("R5", {3'b0, hs, ls, errn}, 8'h07);

      req = "R6"; lsh = 1;
      cyc(25);
      lsh = 0;
      check("R6", {7'b0, errn}, 8'h00);
      cmd = 2'b00;
      cyc(12);
      check("R6", {3'b0, hs, ls, errn}, 8'h00);
      cmd = 2'b11;
      cyc(12);
      check("R6", {7'b0, errn}, 8'h00);

      req = "R9"; slow = 1; sgood = 0;
      cyc(3);
      check("R9", {7'b0, errn}, 8'h00);
      slow = 0; sgood = 1;
      cyc(3);
      check("R9", {7'b0, errn}, 8'h01);
      cmd = 2'b00;
      cyc(12);
      check("R9", {3'b0, hs, ls, errn}, 8'h0D);

      req = "R10"; lsh = 1;
      cyc(25);
      lsh = 0;
      check("R10", {7'b0, errn}, 8'h00);
      rst_n = 1'b0;
      cyc(2);
      check("R10", {3'b0, hs, ls, errn}, 8'h00);
      rst_n = 1'b1;
      cyc(3);
      check("R10", {7'b0, errn}, 8'h01);
      cyc(10);
      check("R10", {3'b0, hs, ls, errn}, 8'h0D);

      req = "R8"; hot = 1; cool = 0;
      cyc(1);
      hot = 0;
      cyc(3);
      check("R8", {3'b0, hs, ls, errn}, 8'h00);
      cyc(10);
      check("R8", {7'b0, errn}, 8'h00);
      cool = 1;
      cyc(8);
      check("R8", {3'b0, hs, ls, errn}, 8'h0D);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule